// File: doc/BRIEF.md
# Paged Displacement Address Generator

This block builds the 20-bit byte address for a data access. The source is one of four 16-bit address registers. Each of those registers has its own 4-bit page register, which supplies the top four address bits. The block has three ways to form the address:

- plain register indirect;
- register plus a short word displacement, which stays inside a 16-word window;
- a short absolute zero-page location.

The block also drives the two byte-lane write strobes and steers read data for byte loads. The address registers themselves live elsewhere and arrive as one flat input bus. The page registers are held here and are loaded by a page-write strobe, the set-page operation.

The address, the lane strobes and the steered read data are purely combinational. They follow the current inputs and the current page contents. A page write becomes visible on the edge after it is presented, so an access in the same cycle as the write still sees the old page.

Top module: `pagedAddrGen`

## Requirements
- R1: With `accMode` = 0 (register indirect), bits 15..1 of `memAddr` equal the selected register's bits 15..1, and `dispField` has no effect on `memAddr`.
- R2: With `accMode` = 1 or 3 (displacement), `memAddr[4:1]` equals (register bits 4..1 + `dispField[3:0]`) mod 16, and every other bit of bits 15..1 comes straight from the register.
- R3: In displacement mode, no carry leaves bit 4: `memAddr[15:5]` always equals the selected register's bits 15..5.
- R4: In modes 0, 1 and 3, `memAddr[19:16]` is the page register paired with `accSel`. When `pageWrEn` is high at a rising clock edge, the page register numbered `pageWrSel` takes `pageWrData`, and the other page registers keep their values. An access in the same cycle as the write still uses the old value.
- R5: While `rstN` is low, all page registers clear to 0.
- R6: With `accMode` = 2 (zero page), `memAddr` = `dispField` × 2. Bits 19..8 and bit 0 are zero.
- R7: When `byteMode` = 0 (word access), `memAddr[0]` is 0. When `byteMode` = 1 in modes 0, 1 and 3, `memAddr[0]` is the register's bit 0.
- R8: If `byteMode` = 1 and `memAddr[0]` = 1, `alignedRdData` = {`rdData[15:8]`, `rdData[15:8]`}. Otherwise `alignedRdData` = `rdData`. Bit 0 of `wrLaneEn` is the low byte (bits 7..0) and bit 1 is the high byte.
- R9: `wrLaneEn` is 2'b00 when `writeReq` = 0. It is 2'b11 for a word write. For a byte write it is 2'b01 when `memAddr[0]` = 0 and 2'b10 when `memAddr[0]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears page registers |
| pageWrEn | input | 1 | Load a page register at the next edge |
| pageWrSel | input | 2 | Which page register to load |
| pageWrData | input | 4 | New page value |
| addrRegsFlat | input | 64 | Four 16-bit address registers; register k sits in bits 16k+15..16k |
| accMode | input | 2 | 0 indirect, 1 or 3 displacement, 2 zero page |
| accSel | input | 2 | Address register used for the access |
| dispField | input | 7 | Displacement (low 4 bits) or zero-page word index (all 7 bits) |
| byteMode | input | 1 | 1 = byte access, 0 = word access |
| writeReq | input | 1 | Access is a store |
| rdData | input | 16 | Word read from memory |
| memAddr | output | 20 | Byte address |
| wrLaneEn | output | 2 | Byte-lane write enables |
| alignedRdData | output | 16 | Read data after byte steering |

## Verification
The bench targets the wrap of the 4-bit word displacement at bit 4. A design that let the carry through would step into the next 16-word window, changing bit 5 or above. It also writes a page register in the same cycle that register is used, which exposes a design that forwards the new page early. Odd register values are paired with word accesses to catch a design that leaves A0 set. Byte reads and writes at odd addresses expose a design that clears the high byte or picks the wrong lane, and zero-page accesses catch any page or register bits leaking into the address.

// File: rtl/pagedAddrPkg.sv
package pagedAddrPkg;

  typedef enum logic [1:0] {
    MODE_INDIRECT = 2'd0,
    MODE_DISP     = 2'd1,
    MODE_ZPAGE    = 2'd2,
    MODE_DISP_ALT = 2'd3
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dispEn;
    logic zeroPage;
    logic byteAcc;
    logic storeEn;
  } addrStrobe_t;

endpackage

// File: rtl/addrCtrl.sv
module addrCtrl
  import pagedAddrPkg::*;
(
  input  logic [1:0]  accMode,
  input  logic        byteMode,
  input  logic        writeReq,
  output addrStrobe_t strobe
);

  accMode_e modeDec;

  always_comb begin
    modeDec = accMode_e'(accMode);
    strobe  = '0;
    strobe.byteAcc = byteMode;
    strobe.storeEn = writeReq;
    unique case (modeDec)
      MODE_INDIRECT: begin
        strobe.dispEn   = 1'b0;
        strobe.zeroPage = 1'b0;
      end
      MODE_ZPAGE: begin
        strobe.dispEn   = 1'b0;
        strobe.zeroPage = 1'b1;
      end
      MODE_DISP, MODE_DISP_ALT: begin
        strobe.dispEn   = 1'b1;
        strobe.zeroPage = 1'b0;
      end
      default: begin
        strobe.dispEn   = 1'b0;
        strobe.zeroPage = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pageRegFile.sv
module pageRegFile #(
  parameter int NUM_REGS = 4,
  parameter int PAGE_W   = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageWrEn,
  input  logic [SEL_W-1:0]  pageWrSel,
  input  logic [PAGE_W-1:0] pageWrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [PAGE_W-1:0] rdPage
);

  logic [PAGE_W-1:0] pageQ [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gPage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        pageQ[gi] <= '0;
      else if (pageWrEn && (pageWrSel == SEL_W'(gi)))
        pageQ[gi] <= pageWrData;
    end
  end

  assign rdPage = pageQ[rdSel];

endmodule

// File: rtl/addrDatapath.sv
module addrDatapath
  import pagedAddrPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int DISP_W   = 4,
  parameter int ZP_W     = 7,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int FULL_W  = ADDR_W + PAGE_W,
  localparam int DATA_W  = 16,
  localparam int LANE_W  = DATA_W / 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  addrStrobe_t                strobe,
  input  logic                       pageWrEn,
  input  logic [SEL_W-1:0]           pageWrSel,
  input  logic [PAGE_W-1:0]          pageWrData,
  input  logic [NUM_REGS*ADDR_W-1:0] addrRegsFlat,
  input  logic [SEL_W-1:0]           accSel,
  input  logic [ZP_W-1:0]            dispField,
  input  logic [DATA_W-1:0]          rdData,
  output logic [FULL_W-1:0]          memAddr,
  output logic [LANE_W-1:0]          wrLaneEn,
  output logic [DATA_W-1:0]          alignedRdData
);

  logic [ADDR_W-1:0] regArr [NUM_REGS];
  logic [ADDR_W-1:0] selReg;
  logic [PAGE_W-1:0] selPage;
  logic [DISP_W-1:0] dispAmt;
  logic [DISP_W-1:0] wordIdxSum;
  logic [ADDR_W-1:0] offsetReg;
  logic [FULL_W-1:0] rawAddr;
  logic              lowBit;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gUnpack
    assign regArr[gi] = addrRegsFlat[gi*ADDR_W +: ADDR_W];
  end

  assign selReg = regArr[accSel];

  pageRegFile #(.NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W)) uPages (
    .clk       (clk),
    .rstN      (rstN),
    .pageWrEn  (pageWrEn),
    .pageWrSel (pageWrSel),
    .pageWrData(pageWrData),
    .rdSel     (accSel),
    .rdPage    (selPage)
  );

  // word displacement confined to the 4-bit word index, wraps inside window
  assign dispAmt    = strobe.dispEn ? dispField[DISP_W-1:0] : '0;
  assign wordIdxSum = selReg[DISP_W:1] + dispAmt;

  always_comb begin
    offsetReg           = selReg;
    offsetReg[DISP_W:1] = wordIdxSum;
  end

  always_comb begin
    if (strobe.zeroPage)
      rawAddr = FULL_W'({dispField, 1'b0});
    else
      rawAddr = {selPage, offsetReg};
  end

  assign lowBit = strobe.byteAcc & rawAddr[0];

  always_comb begin
    memAddr    = rawAddr;
    memAddr[0] = lowBit;
  end

  // lane strobes, little-endian
  always_comb begin
    wrLaneEn = '0;
    if (strobe.storeEn) begin
      if (!strobe.byteAcc)
        wrLaneEn = '1;
      else if (lowBit)
        wrLaneEn = LANE_W'(2'b10);
      else
        wrLaneEn = LANE_W'(2'b01);
    end
  end

  // odd byte read: high byte copied down, high byte kept
  always_comb begin
    alignedRdData = rdData;
    if (lowBit)
      alignedRdData[7:0] = rdData[15:8];
  end

endmodule

// File: rtl/pagedAddrGen.sv
module pagedAddrGen
  import pagedAddrPkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int DISP_W   = 4,
  parameter int ZP_W     = 7,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int FULL_W  = ADDR_W + PAGE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pageWrEn,
  input  logic [SEL_W-1:0]           pageWrSel,
  input  logic [PAGE_W-1:0]          pageWrData,
  input  logic [NUM_REGS*ADDR_W-1:0] addrRegsFlat,
  input  logic [1:0]                 accMode,
  input  logic [SEL_W-1:0]           accSel,
  input  logic [ZP_W-1:0]            dispField,
  input  logic                       byteMode,
  input  logic                       writeReq,
  input  logic [15:0]                rdData,
  output logic [FULL_W-1:0]          memAddr,
  output logic [1:0]                 wrLaneEn,
  output logic [15:0]                alignedRdData
);

  addrStrobe_t strobe;

  addrCtrl uCtrl (
    .accMode (accMode),
    .byteMode(byteMode),
    .writeReq(writeReq),
    .strobe  (strobe)
  );

  addrDatapath #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .DISP_W(DISP_W), .ZP_W(ZP_W)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pageWrEn     (pageWrEn),
    .pageWrSel    (pageWrSel),
    .pageWrData   (pageWrData),
    .addrRegsFlat (addrRegsFlat),
    .accSel       (accSel),
    .dispField    (dispField),
    .rdData       (rdData),
    .memAddr      (memAddr),
    .wrLaneEn     (wrLaneEn),
    .alignedRdData(alignedRdData)
  );

endmodule

// File: rtl/addrGenChecker.sv
module addrGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        pageWrEn,
  input logic [63:0] addrRegsFlat,
  input logic [1:0]  accMode,
  input logic [1:0]  accSel,
  input logic [6:0]  dispField,
  input logic        byteMode,
  input logic        writeReq,
  input logic [15:0] rdData,
  input logic [19:0] memAddr,
  input logic [1:0]  wrLaneEn,
  input logic [15:0] alignedRdData
);

  logic [15:0] chkReg;
  assign chkReg = addrRegsFlat[accSel*16 +: 16];

  assert_indirect_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accMode == 2'd0) |-> (memAddr[15:1] == chkReg[15:1]));

  assert_no_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accMode[0] == 1'b1) |-> (memAddr[15:5] == chkReg[15:5]));

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pageWrEn) && $stable(accSel) && accMode != 2'd2 && $past(accMode) != 2'd2)
      |-> $stable(memAddr[19:16]));

  assert_zpage_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accMode == 2'd2) |-> (memAddr[19:8] == 12'd0 && memAddr[0] == 1'b0));

  assert_word_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    !byteMode |-> (memAddr[0] == 1'b0));

  assert_high_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    alignedRdData[15:8] == rdData[15:8]);

  assert_no_store_R9: assert property (@(posedge clk) disable iff (!rstN)
    !writeReq |-> (wrLaneEn == 2'b00));

  assert_byte_lane_R9: assert property (@(posedge clk) disable iff (!rstN)
    (writeReq && byteMode) |-> ($countones(wrLaneEn) == 1 && wrLaneEn[1] == memAddr[0]));

endmodule

bind pagedAddrGen addrGenChecker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .pageWrEn     (pageWrEn),
  .addrRegsFlat (addrRegsFlat),
  .accMode      (accMode),
  .accSel       (accSel),
  .dispField    (dispField),
  .byteMode     (byteMode),
  .writeReq     (writeReq),
  .rdData       (rdData),
  .memAddr      (memAddr),
  .wrLaneEn     (wrLaneEn),
  .alignedRdData(alignedRdData)
);

// File: tb/tb_pagedAddrGen.sv
module tb_pagedAddrGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageWrEn = 1'b0;
  logic [1:0]  pageWrSel = '0;
  logic [3:0]  pageWrData = '0;
  logic [63:0] addrRegsFlat = '0;
  logic [1:0]  accMode = '0;
  logic [1:0]  accSel = '0;
  logic [6:0]  dispField = '0;
  logic        byteMode = 1'b0;
  logic        writeReq = 1'b0;
  logic [15:0] rdData = '0;
  logic [19:0] memAddr;
  logic [1:0]  wrLaneEn;
  logic [15:0] alignedRdData;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int pageM [4];

  pagedAddrGen dut (
    .clk(clk), .rstN(rstN), .pageWrEn(pageWrEn), .pageWrSel(pageWrSel),
    .pageWrData(pageWrData), .addrRegsFlat(addrRegsFlat), .accMode(accMode),
    .accSel(accSel), .dispField(dispField), .byteMode(byteMode),
    .writeReq(writeReq), .rdData(rdData), .memAddr(memAddr),
    .wrLaneEn(wrLaneEn), .alignedRdData(alignedRdData)
  );

  always #10 clk = ~clk;

  // behavioural page model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) pageM[i] = 0;
    end else if (pageWrEn) begin
      pageM[pageWrSel] = pageWrData;
    end
  end

  function automatic int expAddr();
    int r, idx, base;
    r = (addrRegsFlat >> (accSel * 16)) & 16'hFFFF;
    if (accMode == 2) return dispField * 2;
    base = r;
    if (accMode != 0) begin
      idx  = ((r / 2) % 16 + dispField % 16) % 16;
      base = r - ((r / 2) % 16) * 2 + idx * 2;
    end
    if (!byteMode) base = base - (base % 2);
    return pageM[accSel] * 65536 + base;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare all outputs against the model; addrTag names the address requirement
  task automatic checkAll(string addrTag);
    int ea, el, er;
    ea = expAddr();
    if (!writeReq) el = 0;
    else if (!byteMode) el = 3;
    else el = (ea % 2 == 1) ? 2 : 1;
    if (byteMode && (ea % 2 == 1)) er = {rdData[15:8], rdData[15:8]};
    else er = rdData;
    chk(addrTag, memAddr, ea);
    chk("R9 lanes", wrLaneEn, el);
    chk("R8 read", alignedRdData, er);
  endtask

  function automatic string modeTag();
    if (accMode == 0) return "R1";
    if (accMode == 2) return "R6";
    return "R2";
  endfunction

  task automatic setAcc(int m, int s, int d, bit bm, bit wr, int rd);
    accMode = 2'(m); accSel = 2'(s); dispField = 7'(d);
    byteMode = bm; writeReq = wr; rdData = 16'(rd);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    addrRegsFlat = {16'h8ABC, 16'h00FE, 16'h001E, 16'h1001};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R5: pages read 0 after reset on every register
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); setAcc(0, s, 0, 1'b0, 1'b0, 0); #2;
      chk("R5 page reset", memAddr[19:16], 0);
    end

    // R1: displacement ignored in indirect mode
    @(negedge clk); setAcc(0, 3, 5, 1'b1, 1'b0, 16'h1234); #2; checkAll("R1 indirect");
    chk("R1 value", memAddr, 20'h08ABC);

    // R2: plain displacement
    @(negedge clk); setAcc(1, 0, 3, 1'b0, 1'b0, 0); #2; checkAll("R2 disp");
    chk("R2 value", memAddr, 20'h01006);

    // R3: wrap of word index, no carry into bit 5
    @(negedge clk); setAcc(1, 1, 1, 1'b0, 1'b0, 0); #2; checkAll("R3 wrap");
    chk("R3 value", memAddr, 20'h00000);
    @(negedge clk); setAcc(3, 2, 15, 1'b0, 1'b0, 0); #2; checkAll("R3 wrap alt");
    chk("R3 value2", memAddr, 20'h000FC);

    // R4: page write visible only after the edge, others unchanged
    @(negedge clk); setAcc(0, 2, 0, 1'b0, 1'b0, 0);
    pageWrEn = 1'b1; pageWrSel = 2'd2; pageWrData = 4'hA; #2;
    chk("R4 same cycle", memAddr[19:16], 0);
    @(negedge clk); pageWrEn = 1'b0; #2;
    chk("R4 after write", memAddr[19:16], 4'hA);
    @(negedge clk); accSel = 2'd1; #2;
    chk("R4 other kept", memAddr[19:16], 0);

    // R6: zero page ignores register and page
    @(negedge clk); setAcc(2, 2, 7'h7F, 1'b1, 1'b1, 16'hBEEF); #2; checkAll("R6 zpage");
    chk("R6 value", memAddr, 20'h000FE);

    // R7: word access from odd register is forced even
    @(negedge clk); setAcc(0, 0, 0, 1'b0, 1'b1, 16'hA55A); #2; checkAll("R7 word");
    chk("R7 bit0", memAddr[0], 0);
    chk("R9 word lanes", wrLaneEn, 2'b11);

    // R8 and R9: byte at odd address
    @(negedge clk); setAcc(0, 0, 0, 1'b1, 1'b1, 16'hC33C); #2; checkAll("R8 odd byte");
    chk("R8 dup", alignedRdData, 16'hC3C3);
    chk("R9 high lane", wrLaneEn, 2'b10);
    @(negedge clk); setAcc(0, 1, 0, 1'b1, 1'b1, 16'hC33C); #2;
    chk("R8 even byte", alignedRdData, 16'hC33C);
    chk("R9 low lane", wrLaneEn, 2'b01);
    @(negedge clk); writeReq = 1'b0; #2;
    chk("R9 no store", wrLaneEn, 2'b00);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      addrRegsFlat = {$urandom, $urandom};
      setAcc($urandom % 4, $urandom % 4, $urandom % 128,
             1'($urandom), 1'($urandom), $urandom % 65536);
      pageWrEn = 1'($urandom % 3 == 0);
      pageWrSel = 2'($urandom);
      pageWrData = 4'($urandom);
      #2;
      checkAll(modeTag());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule